// File: doc/BRIEF.md
# Framer Overhead Error Injector

This block sits in the transmit path of a T3/E3 framer and corrupts chosen overhead bits on command. The serial transmit stream arrives with one strobe per overhead slot type: F-bit, M-bit, C-bit parity (CP) bit, FAS bit, and a frame-start marker. The block passes the stream through one register stage. It inverts bits in selected slots when an error event has been armed.

Two kinds of event exist. A parity event inverts the three CP bits of one T3 frame. A framing event corrupts F-bits or M-bits in T3, or whole FAS words in E3. A two-bit type code selects a single error or a burst, and a burst is long enough to make the far end lose frame alignment. Events are armed in one of two ways. In register mode a rising edge on an insert control bit arms the event. In manual mode a rising edge on an asynchronous trigger pin arms every insert control bit that is currently high. An armed event waits for the next eligible slot before it inverts anything.

Top module: `ovh_err_inject`

## Requirements
- R1: With `manual_i`=0, a 0-to-1 change of `cp_ins_i` or `fe_ins_i` arms exactly one event. Holding the bit high arms nothing further; it must fall and rise again.
- R2: With `manual_i`=1, a rising edge of `trig_i` (after a two-flop synchronizer) arms one event for each of `cp_ins_i` and `fe_ins_i` that is high, and none for one that is low. Control-bit edges arm nothing in this mode.
- R3: A parity event waits for the next `frame_start_i`. It then inverts the next three `cp_slot_i` bits after that marker, which are the three CP bits of that frame.
- R4: A parity event is never armed while `e3_mode_i`=1 or `cbit_mode_i`=0, so the output is unchanged and `cp_busy_o` stays 0.
- R5: An armed framing event inverts nothing until the next eligible slot. Bits outside the selected slots always pass unchanged.
- R6: With T3 selected (`e3_mode_i`=0), `fe_type_i` selects the pattern: 00 inverts one F-bit, 01 inverts one M-bit, 10 inverts the next four F-bits, and 11 inverts the next three M-bits.
- R7: With E3 selected, a FAS word is the 10 `fas_slot_i` bits counted from index 0, and the normal word is 1111010000. Codes 00 and 10 invert only index 5, giving 1111000000. Codes 01 and 11 invert all ten bits, giving 0000101111. The burst length is 1 word for codes 00 and 01 and 4 words for codes 10 and 11. Corruption starts at the next word boundary.
- R8: The type code and the T3/E3 mode are sampled when the event is armed. Later changes do not alter a pending event or a burst in progress.
- R9: A new arming edge for a kind of event that is already pending or in its burst is ignored. `cp_busy_o` and `fe_busy_o` are 1 from the cycle after arming until the last inversion is done.
- R10: `data_o` and all slot strobe outputs are the inputs delayed by exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 1 | Transmit serial bit |
| frame_start_i | input | 1 | First bit of a frame |
| f_slot_i | input | 1 | Current bit is a T3 F-bit |
| m_slot_i | input | 1 | Current bit is a T3 M-bit |
| cp_slot_i | input | 1 | Current bit is a T3 CP bit |
| fas_slot_i | input | 1 | Current bit is an E3 FAS bit |
| e3_mode_i | input | 1 | 1 = E3, 0 = T3 |
| cbit_mode_i | input | 1 | T3 C-bit parity framing enabled |
| cp_ins_i | input | 1 | Parity error insert control |
| fe_ins_i | input | 1 | Framing error insert control |
| fe_type_i | input | 2 | Framing error type code |
| manual_i | input | 1 | 1 = arm from trigger pin |
| trig_i | input | 1 | Asynchronous manual trigger |
| data_o | output | 1 | Transmit bit, possibly corrupted |
| frame_start_o | output | 1 | Delayed frame-start marker |
| f_slot_o | output | 1 | Delayed F-bit strobe |
| m_slot_o | output | 1 | Delayed M-bit strobe |
| cp_slot_o | output | 1 | Delayed CP strobe |
| fas_slot_o | output | 1 | Delayed FAS strobe |
| cp_busy_o | output | 1 | Parity event outstanding |
| fe_busy_o | output | 1 | Framing event outstanding |

## Verification
The bench builds the block with its default parameters:
- three CP bits per frame;
- a 10-bit FAS word, with index 5 as the single-bit error position;
- burst lengths of four F-bits, three M-bits and four FAS words.

With these values every burst ends within a few 40-bit frames. The bench can therefore sweep all four type codes in both T3 and E3 and compare every output bit against a count of slots seen. It also covers the gating cases, re-arming without a falling edge, type changes after arming, and triggers that arrive while busy.

// File: rtl/ovh_err_pkg.sv
package ovh_err_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_ACT  = 2'd2
  } inj_state_e;
endpackage

// File: rtl/ovh_err_sync.sv
module ovh_err_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/ovh_err_arm.sv
module ovh_err_arm #(
  parameter int N_CTRL = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              manual_i,
  input  logic              trig_rise_i,
  input  logic [N_CTRL-1:0] ctrl_i,
  output logic [N_CTRL-1:0] arm_o
);
  logic [N_CTRL-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_i;
  end

  for (genvar g = 0; g < N_CTRL; g++) begin : g_arm
    assign arm_o[g] = manual_i ? (trig_rise_i & ctrl_i[g])
                               : (ctrl_i[g] & ~ctrl_q[g]);
  end
endmodule

// File: rtl/ovh_err_cp.sv
module ovh_err_cp
  import ovh_err_pkg::*;
#(
  parameter int CP_PER_FRAME = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic enable_i,
  input  logic frame_start_i,
  input  logic cp_slot_i,
  output logic flip_o,
  output logic busy_o
);
  localparam int CW = $clog2(CP_PER_FRAME + 1);
  localparam logic [CW-1:0] LAST = CW'(CP_PER_FRAME - 1);

  inj_state_e    state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (arm_i && enable_i) state_q <= ST_PEND;
        ST_PEND: if (frame_start_i) begin
          state_q <= ST_ACT;
          cnt_q   <= '0;
        end
        ST_ACT: if (cp_slot_i) begin
          if (cnt_q == LAST) state_q <= ST_IDLE;
          else               cnt_q   <= cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign flip_o = (state_q == ST_ACT) & cp_slot_i;
  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/ovh_err_frm.sv
module ovh_err_frm
  import ovh_err_pkg::*;
#(
  parameter int FAS_LEN    = 10,
  parameter int FAS_FLIP   = 5,
  parameter int T3_F_BURST = 4,
  parameter int T3_M_BURST = 3,
  parameter int E3_BURST   = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       arm_i,
  input  logic       e3_i,
  input  logic [1:0] type_i,
  input  logic       f_slot_i,
  input  logic       m_slot_i,
  input  logic       fas_slot_i,
  output logic       flip_o,
  output logic       busy_o
);
  localparam int MAXB = (T3_F_BURST > T3_M_BURST)
                      ? ((T3_F_BURST > E3_BURST) ? T3_F_BURST : E3_BURST)
                      : ((T3_M_BURST > E3_BURST) ? T3_M_BURST : E3_BURST);
  localparam int BW = $clog2(MAXB + 1);
  localparam int IW = $clog2(FAS_LEN);
  localparam logic [IW-1:0] IDX_LAST = IW'(FAS_LEN - 1);
  localparam logic [IW-1:0] IDX_FLIP = IW'(FAS_FLIP);

  inj_state_e    state_q;
  logic [BW-1:0] cnt_q;
  logic [IW-1:0] idx_q;
  logic          e3_q;
  logic [1:0]    type_q;
  logic [BW-1:0] burst;
  logic          unit_slot, start_ok, take, unit_end, bit_hit;

  // FAS bit position within the word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         idx_q <= '0;
    else if (fas_slot_i) idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
  end

  always_comb begin
    unique case ({e3_q, type_q[1]})
      2'b00:   burst = BW'(1);
      2'b01:   burst = type_q[0] ? BW'(T3_M_BURST) : BW'(T3_F_BURST);
      2'b10:   burst = BW'(1);
      default: burst = BW'(E3_BURST);
    endcase
  end

  always_comb begin
    unit_slot = e3_q ? fas_slot_i : (type_q[0] ? m_slot_i : f_slot_i);
    start_ok  = e3_q ? (fas_slot_i && idx_q == '0) : unit_slot;
    take      = ((state_q == ST_PEND) && start_ok) ||
                ((state_q == ST_ACT) && unit_slot);
    unit_end  = e3_q ? (idx_q == IDX_LAST) : 1'b1;
    bit_hit   = e3_q ? (type_q[0] || idx_q == IDX_FLIP) : 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      e3_q    <= 1'b0;
      type_q  <= 2'b00;
    end else if (state_q == ST_IDLE) begin
      if (arm_i) begin
        state_q <= ST_PEND;
        cnt_q   <= '0;
        e3_q    <= e3_i;
        type_q  <= type_i;
      end
    end else if (take) begin
      state_q <= ST_ACT;
      if (unit_end) begin
        if (cnt_q == burst - 1'b1) state_q <= ST_IDLE;
        else                       cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  assign flip_o = take & bit_hit;
  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/ovh_err_inject.sv
module ovh_err_inject #(
  parameter int SYNC_STAGES  = 2,
  parameter int CP_PER_FRAME = 3,
  parameter int FAS_LEN      = 10,
  parameter int FAS_FLIP     = 5,
  parameter int T3_F_BURST   = 4,
  parameter int T3_M_BURST   = 3,
  parameter int E3_BURST     = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       data_i,
  input  logic       frame_start_i,
  input  logic       f_slot_i,
  input  logic       m_slot_i,
  input  logic       cp_slot_i,
  input  logic       fas_slot_i,
  input  logic       e3_mode_i,
  input  logic       cbit_mode_i,
  input  logic       cp_ins_i,
  input  logic       fe_ins_i,
  input  logic [1:0] fe_type_i,
  input  logic       manual_i,
  input  logic       trig_i,
  output logic       data_o,
  output logic       frame_start_o,
  output logic       f_slot_o,
  output logic       m_slot_o,
  output logic       cp_slot_o,
  output logic       fas_slot_o,
  output logic       cp_busy_o,
  output logic       fe_busy_o
);
  localparam int N_CTRL = 2;
  localparam int K_CP   = 0;
  localparam int K_FE   = 1;

  logic              trig_rise;
  logic [N_CTRL-1:0] arm;
  logic              cp_flip, fe_flip;

  ovh_err_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .async_i(trig_i), .rise_o(trig_rise)
  );

  ovh_err_arm #(.N_CTRL(N_CTRL)) u_arm (
    .clk_i, .rst_ni,
    .manual_i,
    .trig_rise_i(trig_rise),
    .ctrl_i     ({fe_ins_i, cp_ins_i}),
    .arm_o      (arm)
  );

  ovh_err_cp #(.CP_PER_FRAME(CP_PER_FRAME)) u_cp (
    .clk_i, .rst_ni,
    .arm_i        (arm[K_CP]),
    .enable_i     (~e3_mode_i & cbit_mode_i),
    .frame_start_i,
    .cp_slot_i,
    .flip_o       (cp_flip),
    .busy_o       (cp_busy_o)
  );

  ovh_err_frm #(
    .FAS_LEN(FAS_LEN), .FAS_FLIP(FAS_FLIP),
    .T3_F_BURST(T3_F_BURST), .T3_M_BURST(T3_M_BURST), .E3_BURST(E3_BURST)
  ) u_frm (
    .clk_i, .rst_ni,
    .arm_i     (arm[K_FE]),
    .e3_i      (e3_mode_i),
    .type_i    (fe_type_i),
    .f_slot_i,
    .m_slot_i,
    .fas_slot_i,
    .flip_o    (fe_flip),
    .busy_o    (fe_busy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o        <= 1'b0;
      frame_start_o <= 1'b0;
      f_slot_o      <= 1'b0;
      m_slot_o      <= 1'b0;
      cp_slot_o     <= 1'b0;
      fas_slot_o    <= 1'b0;
    end else begin
      data_o        <= data_i ^ (cp_flip | fe_flip);
      frame_start_o <= frame_start_i;
      f_slot_o      <= f_slot_i;
      m_slot_o      <= m_slot_i;
      cp_slot_o     <= cp_slot_i;
      fas_slot_o    <= fas_slot_i;
    end
  end
endmodule

// File: rtl/ovh_err_inject_chk.sv
module ovh_err_inject_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       data_i,
  input logic       frame_start_i,
  input logic       f_slot_i,
  input logic       m_slot_i,
  input logic       cp_slot_i,
  input logic       fas_slot_i,
  input logic       e3_mode_i,
  input logic       cbit_mode_i,
  input logic       fe_ins_i,
  input logic       data_o,
  input logic       frame_start_o,
  input logic       f_slot_o,
  input logic       m_slot_o,
  input logic       cp_slot_o,
  input logic       fas_slot_o,
  input logic       cp_busy_o,
  input logic       fe_busy_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_strobe_delay_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> {frame_start_o, f_slot_o, m_slot_o, cp_slot_o, fas_slot_o} ==
                $past({frame_start_i, f_slot_i, m_slot_i, cp_slot_i, fas_slot_i}));

  assert_idle_passthru_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(cp_busy_o) && !$past(fe_busy_o)) |-> data_o == $past(data_i));

  assert_flip_in_slot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && data_o != $past(data_i)) |->
      $past(f_slot_i | m_slot_i | cp_slot_i | fas_slot_i));

  assert_cp_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(e3_mode_i || !cbit_mode_i) && !$past(cp_busy_o)) |-> !cp_busy_o);

  assert_fe_arm_ctrl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(fe_busy_o) && fe_busy_o) |-> $past(fe_ins_i));
endmodule

bind ovh_err_inject ovh_err_inject_chk chk_i (
  .clk_i, .rst_ni, .data_i, .frame_start_i, .f_slot_i, .m_slot_i, .cp_slot_i,
  .fas_slot_i, .e3_mode_i, .cbit_mode_i, .fe_ins_i, .data_o, .frame_start_o,
  .f_slot_o, .m_slot_o, .cp_slot_o, .fas_slot_o, .cp_busy_o, .fe_busy_o
);

// File: tb/ovh_err_inject_tb.sv
module ovh_err_inject_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  FRAME_LEN  = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic data_i = 0, fs_i = 0, f_i = 0, m_i = 0, cp_i = 0, fas_i = 0;
  logic e3 = 0, cbit = 1, cp_ins = 0, fe_ins = 0, manual = 0, trig = 0;
  logic [1:0] ftype = 2'b00;
  logic data_o, fs_o, f_o, m_o, cp_o, fas_o, cp_busy, fe_busy;
  int n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ovh_err_inject dut_i (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data_i), .frame_start_i(fs_i),
    .f_slot_i(f_i), .m_slot_i(m_i), .cp_slot_i(cp_i), .fas_slot_i(fas_i),
    .e3_mode_i(e3), .cbit_mode_i(cbit), .cp_ins_i(cp_ins), .fe_ins_i(fe_ins),
    .fe_type_i(ftype), .manual_i(manual), .trig_i(trig),
    .data_o(data_o), .frame_start_o(fs_o), .f_slot_o(f_o), .m_slot_o(m_o),
    .cp_slot_o(cp_o), .fas_slot_o(fas_o), .cp_busy_o(cp_busy), .fe_busy_o(fe_busy)
  );

  task automatic check(input logic [4:0] act, input logic [4:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    idle(2); trig = 1'b0;
    idle(5);
  endtask

  // ef/em: T3 F/M flips expected, ecp: CP flips in first frame,
  // ew: E3 words corrupted, eall: whole-word inversion
  task automatic run_stream(input int nfr, input bit lay_e3, input int ef, input int em,
                            input bit ecp, input int ew, input bit eall, input string tag);
    int fseen = 0, mseen = 0;
    logic [4:0] exp_strb = '0;
    logic exp_d = 1'b0;
    bit have = 1'b0;
    for (int fr = 0; fr < nfr; fr++) begin
      for (int p = 0; p < FRAME_LEN; p++) begin
        logic d, fl, sf, sm, sc, sa;
        @(negedge clk);
        if (have) begin
          check({4'b0, data_o}, {4'b0, exp_d}, tag);
          check({fs_o, f_o, m_o, cp_o, fas_o}, exp_strb, "R10");
        end
        fl = 1'b0; sf = 0; sm = 0; sc = 0; sa = 0;
        if (lay_e3) begin
          sa = (p < 10);
          d  = sa ? (p < 4 || p == 5) : 1'((p ^ fr) & 1);
          if (sa && fr < ew && (eall || p == 5)) fl = 1'b1;
        end else begin
          sf = (p % 10 == 5);
          sm = (p == 10 || p == 30);
          sc = (p == 12 || p == 22 || p == 32);
          d  = 1'(((p ^ fr) ^ (p >> 2)) & 1);
          if (sf) begin fl = (fseen < ef); fseen++; end
          if (sm) begin fl = (mseen < em); mseen++; end
          if (sc) fl = ecp && fr == 0;
        end
        data_i = d; fs_i = (p == 0); f_i = sf; m_i = sm; cp_i = sc; fas_i = sa;
        exp_d = d ^ fl;
        exp_strb = {(p == 0), sf, sm, sc, sa};
        have = 1'b1;
      end
    end
    @(negedge clk);
    check({4'b0, data_o}, {4'b0, exp_d}, tag);
    data_i = 0; fs_i = 0; f_i = 0; m_i = 0; cp_i = 0; fas_i = 0;
    idle(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    check({data_o, fs_o, cp_busy, fe_busy, f_o}, 5'b0, "reset R10");

    // R3 parity event, then R1 held bit does not re-arm
    cp_ins = 1'b1; idle(2);
    check({4'b0, cp_busy}, 5'd1, "R9 busy after arm");
    run_stream(2, 0, 0, 0, 1, 0, 0, "R3");
    check({4'b0, cp_busy}, 5'd0, "R9 busy cleared");
    run_stream(2, 0, 0, 0, 0, 0, 0, "R1 held high");
    cp_ins = 1'b0; idle(2);

    // R4 gating
    e3 = 1'b1; cp_ins = 1'b1; idle(2);
    check({4'b0, cp_busy}, 5'd0, "R4 e3 busy");
    run_stream(2, 0, 0, 0, 0, 0, 0, "R4 e3");
    cp_ins = 1'b0; e3 = 1'b0; cbit = 1'b0; idle(2);
    cp_ins = 1'b1; idle(2);
    check({4'b0, cp_busy}, 5'd0, "R4 cbit busy");
    run_stream(2, 0, 0, 0, 0, 0, 0, "R4 cbit off");
    cp_ins = 1'b0; cbit = 1'b1; idle(2);

    // R5 R6 T3 codes
    for (int c = 0; c < 4; c++) begin
      ftype = 2'(c);
      fe_ins = 1'b1; idle(2);
      case (c)
        0: run_stream(3, 0, 1, 0, 0, 0, 0, "R6 R5 code00");
        1: run_stream(3, 0, 0, 1, 0, 0, 0, "R6 R5 code01");
        2: run_stream(3, 0, 4, 0, 0, 0, 0, "R6 code10");
        default: run_stream(3, 0, 0, 3, 0, 0, 0, "R6 code11");
      endcase
      fe_ins = 1'b0; idle(2);
    end

    // R7 E3 codes
    e3 = 1'b1;
    for (int c = 0; c < 4; c++) begin
      ftype = 2'(c);
      fe_ins = 1'b1; idle(2);
      run_stream(6, 1, 0, 0, 0, (c >= 2) ? 4 : 1, c[0], "R7");
      check({4'b0, fe_busy}, 5'd0, "R7 busy done");
      fe_ins = 1'b0; idle(2);
    end
    e3 = 1'b0;

    // R8 type and mode sampled at arm
    ftype = 2'b00; fe_ins = 1'b1; idle(2);
    ftype = 2'b10; e3 = 1'b1; idle(2);
    run_stream(3, 0, 1, 0, 0, 0, 0, "R8");
    fe_ins = 1'b0; e3 = 1'b0; idle(2);

    // R2 manual trigger
    manual = 1'b1; ftype = 2'b01; fe_ins = 1'b1; idle(4);
    check({3'b0, cp_busy, fe_busy}, 5'd0, "R2 no arm on bit edge");
    pulse_trig();
    run_stream(3, 0, 0, 1, 0, 0, 0, "R2 fe");
    fe_ins = 1'b0; cp_ins = 1'b1; idle(4);
    check({3'b0, cp_busy, fe_busy}, 5'd0, "R2 cp bit edge");
    pulse_trig();
    check({3'b0, cp_busy, fe_busy}, 5'b00010, "R2 only cp armed");
    run_stream(2, 0, 0, 0, 1, 0, 0, "R2 cp");
    cp_ins = 1'b0; idle(2);

    // R9 retrigger while busy
    ftype = 2'b10; fe_ins = 1'b1; idle(2);
    pulse_trig();
    check({4'b0, fe_busy}, 5'd1, "R9 busy");
    pulse_trig();
    run_stream(3, 0, 4, 0, 0, 0, 0, "R9");
    check({4'b0, fe_busy}, 5'd0, "R9 idle");
    fe_ins = 1'b0; manual = 1'b0; idle(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule